// File: doc/BRIEF.md
# Trigger Window Hit Matcher

This block sits behind a time digitizer that stamps hits against a free-running 40 MHz time base. It owns that time base and publishes it on `time_now` so that the hit source can stamp hits with it. Hits (a channel number and a timestamp) are written into a circular buffer as they arrive. The buffer assumes that timestamps arrive in non-decreasing order. When a trigger strobe arrives, the block records the current time as the trigger time and queues the trigger together with its event and bunch identifiers. It then frames an event made of a header word, one word for each buffered hit whose age relative to the trigger time lies inside the match window, and a trailer word.

The trigger latency equals the match window, so the window closes exactly at the trigger time. The buffer is scanned over a slightly wider search window, and hits that grow older than that window are purged while no trigger is pending. All timestamp arithmetic is modular, so windows that span a rollover of the time base behave the same as any other window. With matching disabled, the block drains the buffer one hit per cycle as plain hit words and ignores triggers.

Top module: `trig_hit_matcher`

## Requirements
- R1: During reset `out_valid` is 0 and `time_now` is 0. After reset `time_now` increases by one every cycle, modulo 2^12.
- R2: For a trigger sampled while `time_now`=T, every buffered hit with age a=(T-ts) mod 4096 in the range 0..39 is output exactly once, in arrival order, between that event's header and trailer.
- R3: Hits with an age of 40 or more, and hits stamped after the trigger time (age of 2048 or more when taken as a 12-bit modular difference), are not output for that trigger.
- R4: Selection gives the same result when the window spans the rollover of the 12-bit time base.
- R5: While no trigger is pending and matching is enabled, a hit whose age relative to `time_now` reaches 48 is removed from the buffer, so a later drain in bypass mode does not output it.
- R6: The header word is {4'hA, digitizer id[3:0], event id[11:0], bunch id[11:0]}, MSB first.
- R7: A hit word is {4'h4, digitizer id[3:0], 7'b0, channel[4:0], timestamp[11:0]}, MSB first.
- R8: The trailer word is {4'hC, digitizer id[3:0], overflow bit, 11'b0, word count[11:0]}. The word count includes the header and the trailer.
- R9: The hit buffer holds DEPTH hits. A hit that arrives while the buffer is full is dropped. The trailer overflow bit is 1 if any hit was dropped since the previous trailer and 0 otherwise.
- R10: Up to 4 triggers wait in a queue. Their events are output back to back in arrival order, each with its own identifiers and window.
- R11: With `match_en`=0, each buffered hit is output as a hit word, one per cycle, in arrival order. No header or trailer is produced, and triggers are ignored and are not framed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst | input | 1 | Synchronous reset, active high |
| match_en | input | 1 | 1 selects window matching, 0 selects bypass drain |
| hit_valid | input | 1 | Hit strobe |
| hit_chan | input | 5 | Channel of the hit |
| hit_ts | input | 12 | Timestamp of the hit |
| trig_valid | input | 1 | Trigger strobe |
| trig_evt | input | 12 | Event identifier for the trigger |
| trig_bunch | input | 12 | Bunch identifier for the trigger |
| time_now | output | 12 | Free-running time base |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 32 | Header, hit or trailer word |

## Verification
The checker relies on the stream of output words alone. It tracks whether an event is open and counts its words, so it assumes that no word with a header or trailer tag is ever produced in bypass mode. The stimulus keeps to this because, with `match_en`=0, the bench only sends hits whose fixed hit tag is 4'h4. The bench also stamps hits in non-decreasing order and never switches `match_en` while a trigger is pending or being framed, so the arrival-order scan and the bypass drain never overlap.

// File: rtl/trig_hit_matcher.sv
module trig_hit_matcher #(
  parameter int CH_W = 5,
  parameter int TS_W = 12,
  parameter int DEPTH = 256,
  parameter int MATCH_WIN = 40,
  parameter int SEARCH_WIN = 48,
  parameter int TQ_DEPTH = 4,
  parameter logic [3:0] DEV_ID = 4'h3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            match_en,
  input  logic            hit_valid,
  input  logic [CH_W-1:0] hit_chan,
  input  logic [TS_W-1:0] hit_ts,
  input  logic            trig_valid,
  input  logic [11:0]     trig_evt,
  input  logic [11:0]     trig_bunch,
  output logic [TS_W-1:0] time_now,
  output logic            out_valid,
  output logic [31:0]     out_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int QW = $clog2(TQ_DEPTH);
  localparam int HPAD = 24 - CH_W - TS_W;
  localparam logic [TS_W-1:0] MWIN = TS_W'(MATCH_WIN);
  localparam logic [TS_W-1:0] SWIN = TS_W'(SEARCH_WIN);
  localparam logic [AW:0] DEP = (AW+1)'(DEPTH);
  localparam logic [QW:0] TQD = (QW+1)'(TQ_DEPTH);

  typedef enum logic {IDLE, SCAN} state_t;
  state_t state;

  logic [CH_W-1:0] hb_chan [DEPTH];
  logic [TS_W-1:0] hb_ts [DEPTH];
  logic [AW:0] wptr, rptr, sptr, hb_cnt;

  logic [TS_W-1:0] tq_t [TQ_DEPTH];
  logic [11:0] tq_evt [TQ_DEPTH];
  logic [11:0] tq_bunch [TQ_DEPTH];
  logic [QW:0] tq_wp, tq_rp, tq_cnt;

  logic [11:0] wcnt;
  logic drop_f;
  logic [31:0] nxt_data;

  assign hb_cnt = wptr - rptr;
  assign tq_cnt = tq_wp - tq_rp;

  wire hb_full  = hb_cnt == DEP;
  wire hb_empty = wptr == rptr;
  wire tq_empty = tq_wp == tq_rp;
  wire tq_full  = tq_cnt == TQD;

  wire hb_push = hit_valid && !hb_full;
  wire hb_drop = hit_valid && hb_full;
  wire tq_push = trig_valid && match_en && !tq_full;

  wire [AW-1:0] hidx = rptr[AW-1:0];
  wire [AW-1:0] sidx = sptr[AW-1:0];
  wire [QW-1:0] qidx = tq_rp[QW-1:0];

  wire [TS_W-1:0] head_age = time_now - hb_ts[hidx];
  wire [TS_W-1:0] s_age = tq_t[qidx] - hb_ts[sidx];

  wire idle_free = state == IDLE && tq_empty && !hb_empty;
  wire bpop  = idle_free && !match_en;
  wire purge = idle_free && match_en && !head_age[TS_W-1] && head_age >= SWIN;
  wire start = state == IDLE && !tq_empty;
  wire scan_end = (sptr == wptr) || s_age[TS_W-1];
  wire s_hit = state == SCAN && !scan_end && s_age < MWIN;
  wire finish = state == SCAN && scan_end;

  function automatic logic [31:0] hit_word(logic [CH_W-1:0] ch, logic [TS_W-1:0] ts);
    return {4'h4, DEV_ID, {HPAD{1'b0}}, ch, ts};
  endfunction

  always_comb begin
    nxt_data = '0;
    if (start)
      nxt_data = {4'hA, DEV_ID, tq_evt[qidx], tq_bunch[qidx]};
    else if (finish)
      nxt_data = {4'hC, DEV_ID, drop_f | hb_drop, 11'b0, wcnt + 12'd1};
    else if (s_hit)
      nxt_data = hit_word(hb_chan[sidx], hb_ts[sidx]);
    else if (bpop)
      nxt_data = hit_word(hb_chan[hidx], hb_ts[hidx]);
  end

  always_ff @(posedge clk) begin
    if (hb_push) begin
      hb_chan[wptr[AW-1:0]] <= hit_chan;
      hb_ts[wptr[AW-1:0]] <= hit_ts;
    end
    if (tq_push) begin
      tq_t[tq_wp[QW-1:0]] <= time_now;
      tq_evt[tq_wp[QW-1:0]] <= trig_evt;
      tq_bunch[tq_wp[QW-1:0]] <= trig_bunch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= IDLE;
      time_now <= '0;
      wptr <= '0;
      rptr <= '0;
      sptr <= '0;
      tq_wp <= '0;
      tq_rp <= '0;
      wcnt <= '0;
      drop_f <= 1'b0;
      out_valid <= 1'b0;
      out_data <= '0;
    end else begin
      time_now <= time_now + 1'b1;
      if (hb_push) wptr <= wptr + 1'b1;
      if (bpop || purge) rptr <= rptr + 1'b1;
      if (tq_push) tq_wp <= tq_wp + 1'b1;
      drop_f <= finish ? 1'b0 : (drop_f | hb_drop);
      out_valid <= start || (state == SCAN && (s_hit || scan_end)) || bpop;
      out_data <= nxt_data;
      if (start) begin
        state <= SCAN;
        sptr <= rptr;
        wcnt <= 12'd1;
      end else if (state == SCAN) begin
        if (scan_end) begin
          state <= IDLE;
          tq_rp <= tq_rp + 1'b1;
        end else begin
          sptr <= sptr + 1'b1;
          if (s_hit) wcnt <= wcnt + 12'd1;
        end
      end
    end
  end
endmodule

// File: rtl/hm_checker.sv
module hm_checker #(
  parameter int TS_W = 12,
  parameter int AW = 8,
  parameter int QW = 2,
  parameter int DEPTH = 256,
  parameter int TQ_DEPTH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            out_valid,
  input logic [31:0]     out_data,
  input logic [TS_W-1:0] time_now,
  input logic [AW:0]     hb_cnt,
  input logic [QW:0]     tq_cnt
);
  logic in_evt;
  logic [11:0] wc;
  wire is_hdr = out_valid && out_data[31:28] == 4'hA;
  wire is_trl = out_valid && out_data[31:28] == 4'hC;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_evt <= 1'b0;
      wc <= '0;
    end else if (is_hdr) begin
      in_evt <= 1'b1;
      wc <= 12'd1;
    end else if (is_trl) begin
      in_evt <= 1'b0;
    end else if (out_valid && in_evt) begin
      wc <= wc + 12'd1;
    end
  end

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> time_now == $past(time_now) + TS_W'(1)); // R1
  AST_HDR_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    is_hdr |-> !in_evt); // R6
  AST_TRL_INSIDE: assert property (@(posedge clk) disable iff (rst)
    is_trl |-> in_evt); // R8
  AST_TRL_COUNT: assert property (@(posedge clk) disable iff (rst)
    is_trl |-> out_data[11:0] == wc + 12'd1); // R8
  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (rst)
    hb_cnt <= (AW+1)'(DEPTH)); // R9
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
    tq_cnt <= (QW+1)'(TQ_DEPTH)); // R10
endmodule

bind trig_hit_matcher hm_checker #(
  .TS_W(TS_W), .AW(AW), .QW(QW), .DEPTH(DEPTH), .TQ_DEPTH(TQ_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_data(out_data),
  .time_now(time_now), .hb_cnt(hb_cnt), .tq_cnt(tq_cnt)
);

// File: tb/sim_trig_hit_matcher.sv
module sim_trig_hit_matcher;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] DEV = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic match_en = 1'b1;
  logic hit_valid = 1'b0;
  logic [4:0] hit_chan = '0;
  logic [11:0] hit_ts = '0;
  logic trig_valid = 1'b0;
  logic [11:0] trig_evt = '0;
  logic [11:0] trig_bunch = '0;
  logic [11:0] time_now;
  logic out_valid;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] got[$];
  logic [31:0] exp_q[$];

  trig_hit_matcher #(.DEPTH(16), .DEV_ID(DEV)) u0 (
    .clk(clk), .rst(rst), .match_en(match_en), .hit_valid(hit_valid),
    .hit_chan(hit_chan), .hit_ts(hit_ts), .trig_valid(trig_valid),
    .trig_evt(trig_evt), .trig_bunch(trig_bunch), .time_now(time_now),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (!rst && out_valid) got.push_back(out_data);

  function automatic logic [31:0] hdr(logic [11:0] e, logic [11:0] b);
    return {4'hA, DEV, e, b};
  endfunction
  function automatic logic [31:0] hw(logic [4:0] ch, logic [11:0] ts);
    return {4'h4, DEV, 7'b0, ch, ts};
  endfunction
  function automatic logic [31:0] trl(logic ovf, logic [11:0] cnt);
    return {4'hC, DEV, ovf, 11'b0, cnt};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk({req, " word count"}, 32'(got.size()), 32'(exp_q.size()));
    if (got.size() == exp_q.size())
      foreach (exp_q[i]) chk(req, got[i], exp_q[i]);
    got.delete();
    exp_q.delete();
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_hit(logic [4:0] ch, logic [11:0] ts);
    hit_valid = 1'b1; hit_chan = ch; hit_ts = ts;
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic fire(logic [11:0] e, logic [11:0] b);
    trig_valid = 1'b1; trig_evt = e; trig_bunch = b;
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic drain();
    idle(80);
    got.delete();
  endtask

  task automatic t_reset();
    chk("R1 out_valid in reset", 32'(out_valid), 0);
    chk("R1 time_now in reset", 32'(time_now), 0);
    rst = 1'b0;
    idle(3);
    chk("R1 time_now after release", 32'(time_now), 3);
    got.delete();
  endtask

  task automatic t_window(string req, logic [11:0] evt);
    logic [11:0] t0 = time_now;
    logic [11:0] tt = t0 + 12'd7;
    int ages[7] = '{50, 45, 40, 39, 10, 0, -3};
    foreach (ages[i]) send_hit(5'(i + 1), tt - 12'(ages[i]));
    fire(evt, tt);
    idle(30);
    exp_q.push_back(hdr(evt, tt));
    exp_q.push_back(hw(5'd4, tt - 12'd39));
    exp_q.push_back(hw(5'd5, tt - 12'd10));
    exp_q.push_back(hw(5'd6, tt));
    exp_q.push_back(trl(1'b0, 12'd5));
    compare(req);
  endtask

  task automatic t_wrap();
    while (time_now != 12'd4090) @(negedge clk);
    t_window("R4 R2 R3 window across rollover", 12'h0B7);
  endtask

  task automatic t_purge();
    logic [11:0] t0 = time_now;
    for (int i = 0; i < 3; i++) send_hit(5'(i), t0 + 12'(i));
    idle(70);
    match_en = 1'b0;
    idle(10);
    compare("R5 stale hits purged before bypass drain");
    match_en = 1'b1;
  endtask

  task automatic t_bypass();
    logic [11:0] t0;
    match_en = 1'b0;
    idle(2);
    fire(12'h055, 12'h066);
    t0 = time_now;
    send_hit(5'd1, t0);
    send_hit(5'd2, t0 + 12'd1);
    send_hit(5'd3, t0 + 12'd1);
    idle(10);
    match_en = 1'b1;
    idle(20);
    exp_q.push_back(hw(5'd1, t0));
    exp_q.push_back(hw(5'd2, t0 + 12'd1));
    exp_q.push_back(hw(5'd3, t0 + 12'd1));
    compare("R11 bypass drains hits and ignores trigger");
  endtask

  task automatic t_queue();
    logic [11:0] t0 = time_now;
    logic [11:0] tt = t0 + 12'd2;
    send_hit(5'd9, tt - 12'd39);
    send_hit(5'd10, tt - 12'd5);
    fire(12'd10, 12'd100);
    fire(12'd11, 12'd101);
    fire(12'd12, 12'd102);
    idle(40);
    exp_q.push_back(hdr(12'd10, 12'd100));
    exp_q.push_back(hw(5'd9, tt - 12'd39));
    exp_q.push_back(hw(5'd10, tt - 12'd5));
    exp_q.push_back(trl(1'b0, 12'd4));
    exp_q.push_back(hdr(12'd11, 12'd101));
    exp_q.push_back(hw(5'd10, tt - 12'd5));
    exp_q.push_back(trl(1'b0, 12'd3));
    exp_q.push_back(hdr(12'd12, 12'd102));
    exp_q.push_back(hw(5'd10, tt - 12'd5));
    exp_q.push_back(trl(1'b0, 12'd3));
    compare("R10 queued triggers framed in order");
  endtask

  task automatic t_overflow();
    logic [11:0] t0 = time_now;
    logic [11:0] tt = t0 + 12'd20;
    for (int i = 0; i < 20; i++) send_hit(5'(i), tt - 12'(39 - i));
    fire(12'h0F0, 12'h0F1);
    idle(40);
    exp_q.push_back(hdr(12'h0F0, 12'h0F1));
    for (int i = 0; i < 16; i++) exp_q.push_back(hw(5'(i), tt - 12'(39 - i)));
    exp_q.push_back(trl(1'b1, 12'd18));
    compare("R9 full buffer drops hits and flags trailer");
    drain();
    fire(12'h0F2, 12'h0F3);
    idle(10);
    exp_q.push_back(hdr(12'h0F2, 12'h0F3));
    exp_q.push_back(trl(1'b0, 12'd2));
    compare("R9 overflow flag cleared after trailer");
  endtask

  initial begin
    idle(4);
    t_reset();
    t_window("R2 R3 R6 R7 R8 basic window", 12'h123);
    drain();
    t_purge();
    drain();
    t_bypass();
    drain();
    t_queue();
    drain();
    t_overflow();
    drain();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule